// File: doc/BRIEF.md
# Register Stack Frame Mapper

This block keeps track of procedure frames carved out of a pool of 96 stacked physical registers, numbered 32 to 127, which it treats as a ring. A procedure sizes its frame with an allocate operation that gives a local count and a total count. A call hides the caller's locals and moves the base forward, so that the caller's output registers show up to the callee from register 32 upward. A return takes the saved frame marker off a small internal stack and puts back the caller's base and sizes.

A combinational lookup turns a frame-relative register number into its physical register. It also flags any reference beyond the current frame. The ring can hold too little for a new frame, or a returning caller's locals can already have been pushed out to memory. In either case the block asks an external memory engine to move a counted block of registers, using a valid/ready handshake. The operation stalls until that handshake completes.

Top module: `reg_frame_mapper`

## Requirements
- R1: After reset, frameBase, frameSol and frameSof are 0, opReady is 1, and spillValid, fillValid and opErr are 0.
- R2: For lookupReg >= 32, physReg = 32 + ((frameBase + lookupReg - 32) mod 96). For lookupReg < 32, physReg equals lookupReg and illegalReg is 0.
- R3: illegalReg is 1 exactly when lookupReg >= 32 and lookupReg - 32 >= frameSof.
- R4: An accepted allocate (opKind 2'b01) sets frameSol to opSol and frameSof to opSof, with frameBase unchanged. When no transfer is needed, the new values are visible from the cycle after acceptance.
- R5: An allocate with opSof > 96 or opSol > opSof raises opErr for one cycle after acceptance, and it leaves frameBase, frameSol and frameSof unchanged.
- R6: An accepted call (opKind 2'b10) pushes the caller marker and moves frameBase to (frameBase + frameSol) mod 96. It sets frameSof to frameSof - frameSol and frameSol to 0, so the caller's register 32+frameSol+i and the callee's register 32+i map to the same physical register.
- R7: An accepted return (opKind 2'b11) pops the newest marker. It restores frameSol and frameSof from the marker and sets frameBase to (frameBase - restored frameSol) mod 96. With no fill needed, this takes effect in the cycle after acceptance.
- R8: Hidden resident registers plus the new frame size can exceed 96 on an allocate. The block then raises spillValid with spillCount equal to the excess and holds spillCount and opReady = 0 until spillReady. The allocate takes effect in the cycle after the handshake.
- R9: On a return, when the caller's local count exceeds the hidden registers still resident, the block raises fillValid with fillCount equal to the shortfall and holds opReady = 0 until fillReady. The return takes effect in the cycle after the handshake, and frameBase does not move before then.
- R10: A call made while the marker stack holds DEPTH entries, or a return made while the stack is empty, raises opErr and leaves the frame state unchanged. opKind 2'b00 is a no-operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | Operation request, taken when opReady is 1 |
| opKind | input | 2 | 00 none, 01 allocate, 10 call, 11 return |
| opSol | input | 7 | Local register count for allocate |
| opSof | input | 7 | Total frame size for allocate |
| opReady | output | 1 | Block can accept an operation |
| opErr | output | 1 | One-cycle pulse after a rejected operation |
| spillValid | output | 1 | Request to move registers to memory |
| spillReady | input | 1 | Memory engine accepts the spill |
| spillCount | output | 7 | Number of registers to spill |
| fillValid | output | 1 | Request to bring registers back from memory |
| fillReady | input | 1 | Memory engine accepts the fill |
| fillCount | output | 7 | Number of registers to fill |
| lookupReg | input | 7 | Frame-relative register number to translate |
| physReg | output | 7 | Physical register number |
| illegalReg | output | 1 | Lookup lies outside the current frame |
| frameBase | output | 7 | Current frame base within the ring, 0 to 95 |
| frameSol | output | 7 | Current local count |
| frameSof | output | 7 | Current total frame size |

## Verification
The mapping is tried in several cases. A frame at base 0 is compared against lookups of static registers. A frame moved by a call tells renumbering apart from a plain offset. A frame whose base plus offset passes 96 shows that the ring wraps rather than overruns, and lookups just inside and just past the frame size show the bound. The sequence of operations covers an allocate that needs no transfer, an allocate that forces a spill, and two nested returns that each force a fill of a different size. Each transfer is held with ready low for several cycles, so that it is clear the state waits for the handshake. Rejected operations (oversize frame, locals larger than the frame, return on an empty stack, call on a full stack) are each followed by a read of the frame outputs, to confirm that nothing moved.

// File: rtl/rsfm_pkg.sv
package rsfm_pkg;

  localparam int REG_W = 7;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_ALLOC = 2'b01,
    OP_CALL  = 2'b10,
    OP_RET   = 2'b11
  } op_e;

  typedef struct packed {
    logic [REG_W-1:0] sol;
    logic [REG_W-1:0] sof;
  } marker_t;

  // strobes from control to datapath
  typedef struct packed {
    logic useHeld;  // evaluate the held operation instead of the live one
    logic holdOp;   // capture the live operation
    logic commit;   // apply the evaluated operation
  } strobe_t;

endpackage

// File: rtl/rsfm_translate.sv
module rsfm_translate
  import rsfm_pkg::*;
#(
  parameter int STACKED = 96,
  parameter int FIRST   = 32
) (
  input  logic [REG_W-1:0] frameBase,
  input  logic [REG_W-1:0] frameSof,
  input  logic [REG_W-1:0] lookupReg,
  output logic [REG_W-1:0] physReg,
  output logic             illegalReg
);

  localparam int SUM_W = REG_W + 1;
  localparam logic [REG_W-1:0] FIRST_R = REG_W'(FIRST);
  localparam logic [SUM_W-1:0] CAP = SUM_W'(STACKED);

  logic             isStacked;
  logic [REG_W-1:0] offset;
  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] wrapped;

  always_comb begin
    isStacked  = lookupReg >= FIRST_R;
    offset     = lookupReg - FIRST_R;
    sum        = {1'b0, frameBase} + {1'b0, offset};
    wrapped    = (sum >= CAP) ? (sum - CAP) : sum;
    physReg    = isStacked ? (FIRST_R + wrapped[REG_W-1:0]) : lookupReg;
    illegalReg = isStacked && (offset >= frameSof);
  end

endmodule

// File: rtl/rsfm_datapath.sv
module rsfm_datapath
  import rsfm_pkg::*;
#(
  parameter int STACKED = 96,
  parameter int DEPTH   = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [1:0]       opKind,
  input  logic [REG_W-1:0] opSol,
  input  logic [REG_W-1:0] opSof,
  output logic             evErr,
  output logic             evSpill,
  output logic             evFill,
  output logic [REG_W-1:0] spillCount,
  output logic [REG_W-1:0] fillCount,
  output logic [REG_W-1:0] frameBase,
  output logic [REG_W-1:0] frameSol,
  output logic [REG_W-1:0] frameSof
);

  localparam int SP_W  = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int SPL_W = $clog2(STACKED * DEPTH + 1);
  localparam int SUM_W = REG_W + 1;
  localparam logic [SUM_W-1:0] CAP = SUM_W'(STACKED);
  localparam logic [SP_W-1:0]  FULL = SP_W'(DEPTH);

  logic [REG_W-1:0] base, sol, sof;
  logic [REG_W-1:0] hidden;       // caller registers still resident in the ring
  logic [SPL_W-1:0] spilled;      // caller registers held in memory
  logic [SP_W-1:0]  sp;
  marker_t          stack [DEPTH];

  op_e              heldKind;
  logic [REG_W-1:0] heldSol, heldSof;

  op_e              evKind;
  logic [REG_W-1:0] evSol, evSof;
  logic [SP_W-1:0]  spMinus;
  logic [IDX_W-1:0] topIdx;
  marker_t          topMark;
  logic [SUM_W-1:0] resTotal;
  logic [SUM_W-1:0] callSum;
  logic [REG_W-1:0] nextBaseCall, nextBaseRet;
  logic [REG_W-1:0] needSpill, needFill;

  always_comb begin
    evKind  = strb.useHeld ? heldKind : op_e'(opKind);
    evSol   = strb.useHeld ? heldSol : opSol;
    evSof   = strb.useHeld ? heldSof : opSof;
    spMinus = sp - SP_W'(1);
    topIdx  = (sp == '0) ? '0 : spMinus[IDX_W-1:0];
    topMark = stack[topIdx];

    resTotal = {1'b0, hidden} + {1'b0, evSof};
    callSum  = {1'b0, base} + {1'b0, sol};
    nextBaseCall = (callSum >= CAP) ? REG_W'(callSum - CAP) : callSum[REG_W-1:0];
    nextBaseRet  = (base >= topMark.sol) ? (base - topMark.sol)
                 : REG_W'(({1'b0, base} + CAP) - {1'b0, topMark.sol});

    evErr     = 1'b0;
    needSpill = '0;
    needFill  = '0;
    case (evKind)
      OP_ALLOC: begin
        if (({1'b0, evSof} > CAP) || (evSol > evSof)) evErr = 1'b1;
        else if (resTotal > CAP) needSpill = REG_W'(resTotal - CAP);
      end
      OP_CALL: begin
        if (sp == FULL) evErr = 1'b1;
      end
      OP_RET: begin
        if (sp == '0) evErr = 1'b1;
        else if (topMark.sol > hidden) needFill = topMark.sol - hidden;
      end
      default: ;
    endcase
    evSpill    = needSpill != '0;
    evFill     = needFill != '0;
    spillCount = needSpill;
    fillCount  = needFill;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      base     <= '0;
      sol      <= '0;
      sof      <= '0;
      hidden   <= '0;
      spilled  <= '0;
      sp       <= '0;
      heldKind <= OP_NONE;
      heldSol  <= '0;
      heldSof  <= '0;
    end else begin
      if (strb.holdOp) begin
        heldKind <= op_e'(opKind);
        heldSol  <= opSol;
        heldSof  <= opSof;
      end
      if (strb.commit) begin
        case (evKind)
          OP_ALLOC: begin
            sol     <= evSol;
            sof     <= evSof;
            hidden  <= hidden - needSpill;
            spilled <= spilled + SPL_W'(needSpill);
          end
          OP_CALL: begin
            base   <= nextBaseCall;
            hidden <= hidden + sol;
            sof    <= sof - sol;
            sol    <= '0;
            sp     <= sp + SP_W'(1);
          end
          OP_RET: begin
            base    <= nextBaseRet;
            sol     <= topMark.sol;
            sof     <= topMark.sof;
            hidden  <= hidden + needFill - topMark.sol;
            spilled <= spilled - SPL_W'(needFill);
            sp      <= spMinus;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strb.commit && (evKind == OP_CALL)) stack[sp[IDX_W-1:0]] <= '{sol: sol, sof: sof};
  end

  assign frameBase = base;
  assign frameSol  = sol;
  assign frameSof  = sof;

  // R8: resident registers never exceed the ring
  a_r8_ring_capacity: assert property (@(posedge clk) disable iff (!rstN)
    ({1'b0, hidden} + {1'b0, sof}) <= CAP);

  // R10: the marker stack stays within its depth
  a_r10_stack_bound: assert property (@(posedge clk) disable iff (!rstN)
    sp <= FULL);

  // R9: a fill never asks for more than was spilled
  a_r9_fill_backed: assert property (@(posedge clk) disable iff (!rstN)
    evFill |-> (SPL_W'(needFill) <= spilled));

  // R4: an allocate leaves the base where it was
  a_r4_alloc_base: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && (evKind == OP_ALLOC)) |=> $stable(base));

endmodule

// File: rtl/rsfm_control.sv
module rsfm_control
  import rsfm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic [1:0] opKind,
  input  logic       evErr,
  input  logic       evSpill,
  input  logic       evFill,
  input  logic       spillReady,
  input  logic       fillReady,
  output strobe_t    strb,
  output logic       opReady,
  output logic       opErr,
  output logic       spillValid,
  output logic       fillValid
);

  typedef enum logic [1:0] {ST_IDLE, ST_SPILL, ST_FILL} state_e;

  state_e state;
  logic   accept;

  always_comb begin
    accept       = (state == ST_IDLE) && opValid && (op_e'(opKind) != OP_NONE);
    strb.useHeld = state != ST_IDLE;
    strb.holdOp  = accept;
    strb.commit  = (accept && !evErr && !evSpill && !evFill)
                 || ((state == ST_SPILL) && spillReady)
                 || ((state == ST_FILL) && fillReady);
    opReady      = state == ST_IDLE;
    spillValid   = state == ST_SPILL;
    fillValid    = state == ST_FILL;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      opErr <= 1'b0;
    end else begin
      opErr <= accept && evErr;
      case (state)
        ST_IDLE: begin
          if (accept && !evErr) begin
            if (evSpill)     state <= ST_SPILL;
            else if (evFill) state <= ST_FILL;
          end
        end
        ST_SPILL: if (spillReady) state <= ST_IDLE;
        ST_FILL:  if (fillReady)  state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  // R8: a spill request is held until taken
  a_r8_spill_hold: assert property (@(posedge clk) disable iff (!rstN)
    (spillValid && !spillReady) |=> spillValid);

  // R9: a fill request is held until taken
  a_r9_fill_hold: assert property (@(posedge clk) disable iff (!rstN)
    (fillValid && !fillReady) |=> fillValid);

  // R8, R9: the two requests are never raised together
  a_r8_one_request: assert property (@(posedge clk) disable iff (!rstN)
    !(spillValid && fillValid));

endmodule

// File: rtl/reg_frame_mapper.sv
module reg_frame_mapper
  import rsfm_pkg::*;
#(
  parameter int STACKED = 96,
  parameter int FIRST   = 32,
  parameter int DEPTH   = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [1:0]       opKind,
  input  logic [REG_W-1:0] opSol,
  input  logic [REG_W-1:0] opSof,
  output logic             opReady,
  output logic             opErr,
  output logic             spillValid,
  input  logic             spillReady,
  output logic [REG_W-1:0] spillCount,
  output logic             fillValid,
  input  logic             fillReady,
  output logic [REG_W-1:0] fillCount,
  input  logic [REG_W-1:0] lookupReg,
  output logic [REG_W-1:0] physReg,
  output logic             illegalReg,
  output logic [REG_W-1:0] frameBase,
  output logic [REG_W-1:0] frameSol,
  output logic [REG_W-1:0] frameSof
);

  strobe_t strb;
  logic    evErr, evSpill, evFill;

  rsfm_control control_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opKind(opKind),
    .evErr(evErr), .evSpill(evSpill), .evFill(evFill),
    .spillReady(spillReady), .fillReady(fillReady),
    .strb(strb), .opReady(opReady), .opErr(opErr),
    .spillValid(spillValid), .fillValid(fillValid)
  );

  rsfm_datapath #(.STACKED(STACKED), .DEPTH(DEPTH)) datapath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .opKind(opKind),
    .opSol(opSol), .opSof(opSof),
    .evErr(evErr), .evSpill(evSpill), .evFill(evFill),
    .spillCount(spillCount), .fillCount(fillCount),
    .frameBase(frameBase), .frameSol(frameSol), .frameSof(frameSof)
  );

  rsfm_translate #(.STACKED(STACKED), .FIRST(FIRST)) translate_i (
    .frameBase(frameBase), .frameSof(frameSof), .lookupReg(lookupReg),
    .physReg(physReg), .illegalReg(illegalReg)
  );

  // R5, R10: a rejected operation leaves the frame untouched
  a_r5_err_state: assert property (@(posedge clk) disable iff (!rstN)
    opErr |-> $stable({frameBase, frameSol, frameSof}));

  // R8: the spill count does not move while waiting
  a_r8_count_stable: assert property (@(posedge clk) disable iff (!rstN)
    (spillValid && !spillReady) |=> $stable(spillCount));

  // R9: the base does not move while a fill waits
  a_r9_base_wait: assert property (@(posedge clk) disable iff (!rstN)
    (fillValid && !fillReady) |=> $stable(frameBase));

endmodule

// File: tb/reg_frame_mapper_tb_top.sv
`timescale 1ns/1ps
module reg_frame_mapper_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       opValid = 1'b0;
  logic [1:0] opKind = 2'b00;
  logic [6:0] opSol = '0, opSof = '0;
  logic       opReady, opErr;
  logic       spillValid, fillValid;
  logic       spillReady = 1'b0, fillReady = 1'b0;
  logic [6:0] spillCount, fillCount;
  logic [6:0] lookupReg = '0;
  logic [6:0] physReg;
  logic       illegalReg;
  logic [6:0] frameBase, frameSol, frameSof;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  reg_frame_mapper dut_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opKind(opKind),
    .opSol(opSol), .opSof(opSof), .opReady(opReady), .opErr(opErr),
    .spillValid(spillValid), .spillReady(spillReady), .spillCount(spillCount),
    .fillValid(fillValid), .fillReady(fillReady), .fillCount(fillCount),
    .lookupReg(lookupReg), .physReg(physReg), .illegalReg(illegalReg),
    .frameBase(frameBase), .frameSol(frameSol), .frameSof(frameSof)
  );

  typedef struct packed {
    logic [1:0] kind;
    logic [6:0] sol;
    logic [6:0] sof;
    logic [1:0] xfer;   // 0 none, 1 spill, 2 fill
    logic [6:0] cnt;
    logic [6:0] eBase;
    logic [6:0] eSol;
    logic [6:0] eSof;
    logic [6:0] look;
    logic [6:0] ePhys;
    logic       eIll;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{2'b01, 7'd10, 7'd15, 2'd0, 7'd0,  7'd0,  7'd10, 7'd15, 7'd46,  7'd46,  1'b0},
    '{2'b01, 7'd10, 7'd15, 2'd0, 7'd0,  7'd0,  7'd10, 7'd15, 7'd47,  7'd47,  1'b1},
    '{2'b10, 7'd0,  7'd0,  2'd0, 7'd0,  7'd10, 7'd0,  7'd5,  7'd32,  7'd42,  1'b0},
    '{2'b01, 7'd20, 7'd30, 2'd0, 7'd0,  7'd10, 7'd20, 7'd30, 7'd61,  7'd71,  1'b0},
    '{2'b10, 7'd0,  7'd0,  2'd0, 7'd0,  7'd30, 7'd0,  7'd10, 7'd32,  7'd62,  1'b0},
    '{2'b01, 7'd50, 7'd80, 2'd1, 7'd14, 7'd30, 7'd50, 7'd80, 7'd102, 7'd36,  1'b0},
    '{2'b11, 7'd0,  7'd0,  2'd2, 7'd4,  7'd10, 7'd20, 7'd30, 7'd32,  7'd42,  1'b0},
    '{2'b11, 7'd0,  7'd0,  2'd2, 7'd10, 7'd0,  7'd10, 7'd15, 7'd5,   7'd5,   1'b0},
    '{2'b01, 7'd0,  7'd96, 2'd0, 7'd0,  7'd0,  7'd0,  7'd96, 7'd127, 7'd127, 1'b0}
  };

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic issue(input logic [1:0] k, input logic [6:0] s, input logic [6:0] f);
    @(negedge clk);
    opValid = 1'b1; opKind = k; opSol = s; opSof = f;
    @(posedge clk);
    @(negedge clk);
    opValid = 1'b0; opKind = 2'b00;
    #0.5;
  endtask

  task automatic look(input logic [6:0] r);
    lookupReg = r;
    #0.5;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [6:0] prevSof, prevBase;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #0.5;
    // R1 reset state
    chk("R1 frameBase", frameBase, 0);
    chk("R1 frameSol", frameSol, 0);
    chk("R1 frameSof", frameSof, 0);
    chk("R1 opReady", opReady, 1);
    chk("R1 spillValid", spillValid, 0);
    chk("R1 fillValid", fillValid, 0);
    chk("R1 opErr", opErr, 0);
    look(7'd32);
    chk("R3 empty frame illegal", illegalReg, 1);

    for (int i = 0; i < NV; i++) begin
      prevSof  = frameSof;
      prevBase = frameBase;
      issue(VECS[i].kind, VECS[i].sol, VECS[i].sof);
      if (VECS[i].xfer == 2'd1) begin
        chk("R8 spillValid", spillValid, 1);
        chk("R8 spillCount", spillCount, VECS[i].cnt);
        chk("R8 stall", opReady, 0);
        repeat (2) @(negedge clk);
        #0.5;
        chk("R8 spill held", spillValid, 1);
        chk("R8 sof waits", frameSof, prevSof);
        spillReady = 1'b1;
        @(posedge clk);
        @(negedge clk);
        spillReady = 1'b0;
        #0.5;
        chk("R8 spill done", spillValid, 0);
      end else if (VECS[i].xfer == 2'd2) begin
        chk("R9 fillValid", fillValid, 1);
        chk("R9 fillCount", fillCount, VECS[i].cnt);
        chk("R9 stall", opReady, 0);
        repeat (2) @(negedge clk);
        #0.5;
        chk("R9 fill held", fillValid, 1);
        chk("R9 base waits", frameBase, prevBase);
        fillReady = 1'b1;
        @(posedge clk);
        @(negedge clk);
        fillReady = 1'b0;
        #0.5;
        chk("R9 fill done", fillValid, 0);
      end else begin
        chk("R4 R6 R7 no transfer", spillValid | fillValid, 0);
      end
      chk("R4 R6 R7 opErr", opErr, 0);
      chk("R4 R6 R7 opReady", opReady, 1);
      chk("R6 R7 frameBase", frameBase, VECS[i].eBase);
      chk("R4 R6 R7 frameSol", frameSol, VECS[i].eSol);
      chk("R4 R6 R7 frameSof", frameSof, VECS[i].eSof);
      look(VECS[i].look);
      chk("R2 physReg", physReg, VECS[i].ePhys);
      chk("R3 illegalReg", illegalReg, VECS[i].eIll);
    end

    // frame is now base 0, sol 0, sof 96 with an empty marker stack
    issue(2'b01, 7'd0, 7'd97);
    chk("R5 oversize opErr", opErr, 1);
    chk("R5 oversize sof kept", frameSof, 96);
    issue(2'b01, 7'd20, 7'd10);
    chk("R5 locals over size opErr", opErr, 1);
    chk("R5 sol kept", frameSol, 0);
    chk("R5 sof kept", frameSof, 96);
    issue(2'b11, 7'd0, 7'd0);
    chk("R10 empty return opErr", opErr, 1);
    chk("R10 empty return base", frameBase, 0);
    issue(2'b00, 7'd5, 7'd5);
    chk("R10 no-op opErr", opErr, 0);
    chk("R10 no-op sof", frameSof, 96);

    for (int c = 0; c < 8; c++) begin
      issue(2'b10, 7'd0, 7'd0);
      chk("R10 call within depth", opErr, 0);
    end
    issue(2'b10, 7'd0, 7'd0);
    chk("R10 full stack opErr", opErr, 1);
    chk("R10 full stack sof", frameSof, 96);
    chk("R10 full stack ready", opReady, 1);
    look(7'd127);
    chk("R2 R3 full frame last reg", {25'd0, illegalReg, physReg}, 127);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule